// File: doc/BRIEF.md
# Host Role Selector with Forced-Host Override

This block decides, cycle by cycle, whether a dual-role USB controller behaves as a host or as a peripheral, and which bus speed it works at. It holds a small test-mode byte, a session flag and a self-clearing soft-reset flag, all written through a simple register write strobe. It watches the controller's ID input, the two-bit line state and a host-disconnect indication. From these it produces a registered host-mode flag, a two-bit speed code and a device-type status bit that software can read.

In normal operation the role comes from the physical indications. The controller becomes host only when the ID input is low and a session is open. A disconnect seen while hosting ends the session. The speed is taken from the line state.

In forced-host operation the physical indications no longer steer the role. Host mode follows the session flag alone and survives a disconnect. The speed comes from the test-mode bits. The device-type status bit then shows the raw disconnect input, so a test can still watch it.

Top module: `host_role_sel`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and after it is released with no writes, `host_mode` is 0, `speed_code` is 2'b01 (full speed) and `dev_type` is 1.
- R2: A write of 8'h80 to address 0 (the test-mode byte) enables forced-host operation with no speed bit set. In that byte, bit 7 is force-host, bit 4 is force-high-speed and bit 5 is force-full-speed.
- R3: In normal operation, one cycle after the ID input is low while the session flag is set, `host_mode` is 1. If `id_pin` is high or the session flag is clear, `host_mode` is 0 one cycle later.
- R4: In normal operation, `dev_type` equals `id_pin` as sampled one cycle earlier.
- R5: In normal operation, `host_discon` high while `host_mode` is 1 clears the session flag. `host_mode` falls two cycles after the disconnect is sampled.
- R6: In forced-host operation, `host_mode` follows only the session flag. `id_pin`, `line_state` and `host_discon` have no effect on it, and a disconnect does not end the session.
- R7: In forced-host operation, `dev_type` equals `host_discon` as sampled one cycle earlier.
- R8: In forced-host operation, `speed_code` is 2'b10 (high) when force-high-speed is set, whatever force-full-speed holds. It is 2'b01 (full) when only force-full-speed is set, and 2'b00 (low) when neither is set.
- R9: In normal operation, `speed_code` is 2'b00 one cycle after `line_state` is 2'b10, and 2'b01 for any other line state.
- R10: Clearing force-host while a session is open drops `host_mode` on the cycle after the clear takes effect, unless `id_pin` is low.
- R11: Writing bit 0 = 1 to address 2 sets a soft-reset flag. On the next edge, every register and output returns to its R1 value and the flag clears itself.
- R12: Bit 0 of a write to address 1 sets or clears the session flag. A write takes priority over a disconnect-driven clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 test-mode, 1 session, 2 control |
| reg_wdata | input | 8 | Write data |
| id_pin | input | 1 | ID input; low requests the host role |
| line_state | input | 2 | Bus line state; 2'b10 marks a low-speed attach |
| host_discon | input | 1 | Host-side disconnect indication |
| host_mode | output | 1 | 1 when the controller acts as host |
| speed_code | output | 2 | 00 low, 01 full, 10 high speed |
| dev_type | output | 1 | Readable device-type status bit |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit address, test-mode bits 7, 4 and 5, and soft-reset bit 0. With these values, the 80h test-mode write and the mixed speed-bit writes exercise the exact bit positions that software uses. The same values let the bench step between normal and forced operation while a session stays open. That brings within reach the disconnect-ends-session path, the disconnect-survives path, and the drop from host mode when the override is removed.

// File: rtl/host_role_pkg.sv
package host_role_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'b00,
    SPD_FULL = 2'b01,
    SPD_HIGH = 2'b10
  } spd_e;

  // Forced speed: high wins over full; neither selects low.
  function automatic spd_e forced_speed(input logic hs, input logic fs);
    if (hs)      return SPD_HIGH;
    else if (fs) return SPD_FULL;
    else         return SPD_LOW;
  endfunction

  // Attach speed from the line: a K-like idle (2'b10) marks a low-speed device.
  function automatic spd_e line_speed(input logic [1:0] ls);
    return (ls == 2'b10) ? SPD_LOW : SPD_FULL;
  endfunction

  // Role decision for the next cycle.
  function automatic logic role_next(input logic force_on, input logic sess,
                                     input logic id);
    if (force_on) return sess;
    else          return sess & ~id;
  endfunction

endpackage

// File: rtl/rsel_regs.sv
module rsel_regs #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int FHOST_BIT = 7,
  parameter int FHS_BIT   = 4,
  parameter int FFS_BIT   = 5,
  parameter int SRST_BIT  = 0,
  parameter int SESS_BIT  = 0,
  parameter logic [ADDR_W-1:0] TM_ADDR   = 0,
  parameter logic [ADDR_W-1:0] SESS_ADDR = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              discon_clr,
  output logic              force_q,
  output logic              fhs_q,
  output logic              ffs_q,
  output logic              session_q,
  output logic              soft_clr
);

  logic wr_tm, wr_sess, wr_ctrl;
  logic srst_q;

  assign wr_tm   = reg_wr && (reg_addr == TM_ADDR);
  assign wr_sess = reg_wr && (reg_addr == SESS_ADDR);
  assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);
  assign soft_clr = srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q   <= 1'b0;
      fhs_q     <= 1'b0;
      ffs_q     <= 1'b0;
      session_q <= 1'b0;
      srst_q    <= 1'b0;
    end else if (srst_q) begin
      force_q   <= 1'b0;
      fhs_q     <= 1'b0;
      ffs_q     <= 1'b0;
      session_q <= 1'b0;
      srst_q    <= 1'b0;
    end else begin
      srst_q <= wr_ctrl && reg_wdata[SRST_BIT];
      if (wr_tm) begin
        force_q <= reg_wdata[FHOST_BIT];
        fhs_q   <= reg_wdata[FHS_BIT];
        ffs_q   <= reg_wdata[FFS_BIT];
      end
      if (wr_sess)         session_q <= reg_wdata[SESS_BIT];
      else if (discon_clr) session_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rsel_role.sv
module rsel_role
  import host_role_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       force_q,
  input  logic       fhs_q,
  input  logic       ffs_q,
  input  logic       session_q,
  input  logic       id_pin,
  input  logic [1:0] line_state,
  input  logic       host_discon,
  output logic       host_q,
  output spd_e       speed_q,
  output logic       devtype_q,
  output logic       discon_clr
);

  logic host_d, devtype_d;
  spd_e speed_d;

  assign host_d    = role_next(force_q, session_q, id_pin);
  assign speed_d   = force_q ? forced_speed(fhs_q, ffs_q) : line_speed(line_state);
  assign devtype_d = force_q ? host_discon : id_pin;
  // Only a normal-mode host session is ended by a disconnect.
  assign discon_clr = !force_q && host_q && host_discon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q    <= 1'b0;
      speed_q   <= SPD_FULL;
      devtype_q <= 1'b1;
    end else if (soft_clr) begin
      host_q    <= 1'b0;
      speed_q   <= SPD_FULL;
      devtype_q <= 1'b1;
    end else begin
      host_q    <= host_d;
      speed_q   <= speed_d;
      devtype_q <= devtype_d;
    end
  end

endmodule

// File: rtl/host_role_sel.sv
module host_role_sel
  import host_role_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int FHOST_BIT = 7,
  parameter int FHS_BIT   = 4,
  parameter int FFS_BIT   = 5,
  parameter int SRST_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              id_pin,
  input  logic [1:0]        line_state,
  input  logic              host_discon,
  output logic              host_mode,
  output logic [1:0]        speed_code,
  output logic              dev_type
);

  localparam logic [ADDR_W-1:0] TM_ADDR   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SESS_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2);

  // Named internal events, also observed by the bound checker.
  logic force_q, fhs_q, ffs_q, session_q, soft_clr, discon_clr;
  spd_e speed_q;

  rsel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FHOST_BIT(FHOST_BIT), .FHS_BIT(FHS_BIT), .FFS_BIT(FFS_BIT),
    .SRST_BIT(SRST_BIT), .SESS_BIT(0),
    .TM_ADDR(TM_ADDR), .SESS_ADDR(SESS_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .discon_clr(discon_clr),
    .force_q(force_q), .fhs_q(fhs_q), .ffs_q(ffs_q),
    .session_q(session_q), .soft_clr(soft_clr)
  );

  rsel_role role_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .force_q(force_q), .fhs_q(fhs_q), .ffs_q(ffs_q),
    .session_q(session_q), .id_pin(id_pin),
    .line_state(line_state), .host_discon(host_discon),
    .host_q(host_mode), .speed_q(speed_q),
    .devtype_q(dev_type), .discon_clr(discon_clr)
  );

  assign speed_code = speed_q;

endmodule

// File: rtl/host_role_sel_chk.sv
module host_role_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_q,
  input logic       fhs_q,
  input logic       session_q,
  input logic       soft_clr,
  input logic       id_pin,
  input logic       host_discon,
  input logic       host_mode,
  input logic [1:0] speed_code,
  input logic       dev_type
);

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!host_mode && speed_code == 2'b01 && dev_type && !session_q && !force_q)); // R11

  AST_SOFT_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !soft_clr); // R11

  AST_FORCED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && session_q && !soft_clr) |=> host_mode); // R6

  AST_NO_SESSION_NO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (!session_q && !soft_clr) |=> !host_mode); // R3

  AST_NORMAL_ID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_q && id_pin && !soft_clr) |=> !host_mode); // R3

  AST_FORCED_DEVTYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && !soft_clr) |=> (dev_type == $past(host_discon))); // R7

  AST_HS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && fhs_q && !soft_clr) |=> (speed_code == 2'b10)); // R8

endmodule

bind host_role_sel host_role_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .force_q(force_q), .fhs_q(fhs_q),
  .session_q(session_q), .soft_clr(soft_clr), .id_pin(id_pin),
  .host_discon(host_discon), .host_mode(host_mode),
  .speed_code(speed_code), .dev_type(dev_type)
);

// File: tb/host_role_sel_tb_top.sv
`timescale 1ns/1ps
module host_role_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       id_pin = 1'b1;
  logic [1:0] line_state = 2'b01;
  logic       host_discon = 1'b0;
  logic       host_mode;
  logic [1:0] speed_code;
  logic       dev_type;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_role_sel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .id_pin(id_pin), .line_state(line_state),
    .host_discon(host_discon), .host_mode(host_mode),
    .speed_code(speed_code), .dev_type(dev_type)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    id_pin = 1'b1; line_state = 2'b01; host_discon = 1'b0;
    wr(2'd2, 8'h01);
    cyc(2);
  endtask

  task automatic t_reset();
    cyc(2);
    check("R1 host in reset", {7'd0, host_mode}, 8'd0);
    check("R1 speed in reset", {6'd0, speed_code}, 8'h01);
    check("R1 devtype in reset", {7'd0, dev_type}, 8'd1);
    rst_n = 1'b1;
    cyc(3);
    check("R1 host after reset", {7'd0, host_mode}, 8'd0);
    check("R1 devtype after reset", {7'd0, dev_type}, 8'd1);
  endtask

  task automatic t_normal_role();
    wr(2'd1, 8'h01);             // R12 session set
    id_pin = 1'b1; cyc(2);
    check("R3 id high no host", {7'd0, host_mode}, 8'd0);
    check("R4 devtype follows id high", {7'd0, dev_type}, 8'd1);
    id_pin = 1'b0; cyc(1);
    check("R3 id low session host", {7'd0, host_mode}, 8'd1);
    check("R4 devtype follows id low", {7'd0, dev_type}, 8'd0);
    wr(2'd1, 8'h00); cyc(1);     // R12 session clear
    check("R12 session clear drops host", {7'd0, host_mode}, 8'd0);
    clean();
  endtask

  task automatic t_normal_discon();
    wr(2'd1, 8'h01);
    id_pin = 1'b0; cyc(2);
    check("R5 host before discon", {7'd0, host_mode}, 8'd1);
    host_discon = 1'b1; cyc(1);
    host_discon = 1'b0; cyc(1);
    check("R5 discon ends host", {7'd0, host_mode}, 8'd0);
    cyc(2);
    check("R5 session stays cleared", {7'd0, host_mode}, 8'd0);
    clean();
  endtask

  task automatic t_forced();
    wr(2'd0, 8'h80);             // R2
    id_pin = 1'b1; line_state = 2'b10; cyc(2);
    check("R2 80h forces but no session no host", {7'd0, host_mode}, 8'd0);
    check("R8 forced neither bit low speed", {6'd0, speed_code}, 8'h00);
    wr(2'd1, 8'h01); cyc(1);
    check("R6 forced host with id high", {7'd0, host_mode}, 8'd1);
    check("R2 80h gives forced host", {7'd0, host_mode}, 8'd1);
    host_discon = 1'b1; line_state = 2'b00; cyc(5);
    check("R6 host survives disconnect", {7'd0, host_mode}, 8'd1);
    check("R7 devtype shows discon high", {7'd0, dev_type}, 8'd1);
    host_discon = 1'b0; cyc(1);
    check("R7 devtype shows discon low", {7'd0, dev_type}, 8'd0);
    check("R6 host still on", {7'd0, host_mode}, 8'd1);
    wr(2'd1, 8'h00); cyc(1);
    check("R6 session clear ends forced host", {7'd0, host_mode}, 8'd0);
    clean();
  endtask

  task automatic t_speed();
    line_state = 2'b10; cyc(1);
    check("R9 line K low speed", {6'd0, speed_code}, 8'h00);
    line_state = 2'b01; cyc(1);
    check("R9 line J full speed", {6'd0, speed_code}, 8'h01);
    wr(2'd0, 8'hB0); cyc(1);
    check("R8 both bits high speed", {6'd0, speed_code}, 8'h02);
    wr(2'd0, 8'hA0); cyc(1);
    check("R8 fs bit full speed", {6'd0, speed_code}, 8'h01);
    wr(2'd0, 8'h90); cyc(1);
    check("R8 hs bit high speed", {6'd0, speed_code}, 8'h02);
    wr(2'd0, 8'h30); line_state = 2'b10; cyc(1);
    check("R2 speed bits ignored without force", {6'd0, speed_code}, 8'h00);
    clean();
  endtask

  task automatic t_force_clear();
    wr(2'd0, 8'h80); wr(2'd1, 8'h01); cyc(1);
    check("R10 forced host up", {7'd0, host_mode}, 8'd1);
    wr(2'd0, 8'h00); cyc(1);
    check("R10 clear force drops host", {7'd0, host_mode}, 8'd0);
    wr(2'd0, 8'h80); cyc(1);
    id_pin = 1'b0;
    wr(2'd0, 8'h00); cyc(1);
    check("R10 id low keeps host", {7'd0, host_mode}, 8'd1);
    clean();
  endtask

  task automatic t_soft();
    wr(2'd0, 8'h90); wr(2'd1, 8'h01); host_discon = 1'b0; cyc(1);
    check("R11 host before soft reset", {7'd0, host_mode}, 8'd1);
    wr(2'd2, 8'h01); cyc(1);
    check("R11 host cleared", {7'd0, host_mode}, 8'd0);
    check("R11 speed default", {6'd0, speed_code}, 8'h01);
    check("R11 devtype default", {7'd0, dev_type}, 8'd1);
    cyc(2);
    check("R11 session cleared no return", {7'd0, host_mode}, 8'd0);
    clean();
  endtask

  initial begin
    t_reset();
    t_normal_role();
    t_normal_discon();
    t_forced();
    t_speed();
    t_force_clear();
    t_soft();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule